// File: doc/BRIEF.md
# Chained BCD Operand Entry Register

This block holds the decimal operands of a sign-magnitude BCD adder. Each operand is a string of digit positions. One stage per position stores one digit of operand A and one digit of operand B. Inside the block the stages are chained, so that the A digits form one shift register and the B digits form another, both four bits wide. A digit is keyed in on four switch lines and enters at the least significant position. On every load pulse the existing digits of the selected operand move one position toward the most significant end. A select line decides which operand takes the new digit, and the other operand keeps its contents.

While the digits sit in the registers, a comparison chain runs from the most significant stage down to the least significant one. It reports whether the magnitude of A is greater than, less than or equal to the magnitude of B. The control logic outside uses this result to decide whether the operands must be exchanged. Setting the swap input then routes B to the minuend output and A to the subtrahend output, so that a subtracter behind this block always receives the larger magnitude on its minuend side.

Top module: `bcd_operand_regs`

## Requirements
- R1: While `rst_n` is low, every digit of A and B reads 0, and `a_gt_b` and `a_lt_b` are both 0. The reset takes effect at once and is released on the clock.
- R2: A clock edge with `load`=1, `sel_b`=0 and `clr`=0 shifts A. Position 0 (bits [3:0]) takes `sw_digit`, and position i takes the old digit of position i-1. The old most significant digit is dropped.
- R3: A clock edge with `load`=1, `sel_b`=1 and `clr`=0 shifts B in the same way as R2, and A keeps its value. In R2 it is B that keeps its value.
- R4: A clock edge with `clr`=1 sets every digit of A and B to 0, and this takes priority over `load`.
- R5: A clock edge with `load`=0 and `clr`=0 leaves A and B unchanged.
- R6: `a_gt_b`=1 exactly when magnitude A is greater than magnitude B, and `a_lt_b`=1 exactly when it is smaller. The most significant digit sits at the top position (bits [11:8] by default), and the first differing digit seen from the top decides. Both outputs are 0 when A equals B, and they follow the registers without a clock.
- R7: With `swap`=0, `min_digits` equals A and `sub_digits` equals B. With `swap`=1, `min_digits` equals B and `sub_digits` equals A. Both are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of both operands |
| load | input | 1 | Single-cycle digit entry pulse |
| sel_b | input | 1 | 0 enters into A, 1 enters into B |
| sw_digit | input | 4 | Digit value entering at position 0 |
| swap | input | 1 | Exchange the operands on the minuend and subtrahend outputs |
| a_digits | output | 12 | Stored A digits, 4 bits per position |
| b_digits | output | 12 | Stored B digits, 4 bits per position |
| min_digits | output | 12 | Minuend-side operand |
| sub_digits | output | 12 | Subtrahend-side operand |
| a_gt_b | output | 1 | Magnitude of A exceeds magnitude of B |
| a_lt_b | output | 1 | Magnitude of A is below magnitude of B |

## Verification
The bench builds the block with its default values, DIGITS=3 and DIGIT_W=4, which give a three-stage chain of 4-bit digits. With three stages, a fourth digit entered into an operand pushes the oldest digit out of the top position. Operand pairs are chosen so that the comparison is decided at the top stage, at the middle stage, at the bottom stage, or not at all. One such pair has a lower digit that points the other way from the deciding top digit, which shows that the top stage wins.

// File: rtl/bcd_reg_pkg.sv
package bcd_reg_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_GT = 2'b01,
    CMP_LT = 2'b10
  } cmp_e;

endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bcd_cmp_cell.sv
module bcd_cmp_cell
  import bcd_reg_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] a_dig,
  input  logic [DIGIT_W-1:0] b_dig,
  input  cmp_e               cmp_in,
  output cmp_e               cmp_out
);

  always_comb begin
    if (cmp_in != CMP_EQ)   cmp_out = cmp_in;
    else if (a_dig > b_dig) cmp_out = CMP_GT;
    else if (a_dig < b_dig) cmp_out = CMP_LT;
    else                    cmp_out = CMP_EQ;
  end

endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_reg_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ld_a,
  input  logic               ld_b,
  input  logic [DIGIT_W-1:0] a_in,
  input  logic [DIGIT_W-1:0] b_in,
  input  logic               swap,
  input  cmp_e               cmp_in,
  output logic [DIGIT_W-1:0] a_q,
  output logic [DIGIT_W-1:0] b_q,
  output logic [DIGIT_W-1:0] min_d,
  output logic [DIGIT_W-1:0] sub_d,
  output cmp_e               cmp_out
);

  logic [DIGIT_W-1:0] a_d;
  logic [DIGIT_W-1:0] b_d;
  logic               a_en;
  logic               b_en;

  always_comb begin
    a_en = clr | ld_a;
    b_en = clr | ld_b;
    a_d  = clr ? '0 : a_in;
    b_d  = clr ? '0 : b_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    a_q <= '0;
    else if (a_en) a_q <= a_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    b_q <= '0;
    else if (b_en) b_q <= b_d;
  end

  always_comb begin
    min_d = swap ? b_q : a_q;
    sub_d = swap ? a_q : b_q;
  end

  bcd_cmp_cell #(.DIGIT_W(DIGIT_W)) u_cmp (
    .a_dig   (a_q),
    .b_dig   (b_q),
    .cmp_in  (cmp_in),
    .cmp_out (cmp_out)
  );

endmodule

// File: rtl/bcd_operand_regs.sv
module bcd_operand_regs
  import bcd_reg_pkg::*;
#(
  parameter int DIGITS  = 3,
  parameter int DIGIT_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        load,
  input  logic                        sel_b,
  input  logic [DIGIT_W-1:0]          sw_digit,
  input  logic                        swap,
  output logic [DIGITS*DIGIT_W-1:0]   a_digits,
  output logic [DIGITS*DIGIT_W-1:0]   b_digits,
  output logic [DIGITS*DIGIT_W-1:0]   min_digits,
  output logic [DIGITS*DIGIT_W-1:0]   sub_digits,
  output logic                        a_gt_b,
  output logic                        a_lt_b
);

  localparam int TOTAL_W = DIGITS * DIGIT_W;

  logic rst_sync_n;
  logic ld_a;
  logic ld_b;
  cmp_e cmp_chain [DIGITS+1];

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ld_a = load & ~sel_b;
    ld_b = load &  sel_b;
  end

  assign cmp_chain[DIGITS] = CMP_EQ;

  for (genvar g = 0; g < DIGITS; g++) begin : g_stage
    logic [DIGIT_W-1:0] a_src;
    logic [DIGIT_W-1:0] b_src;

    if (g == 0) begin : g_lsd
      assign a_src = sw_digit;
      assign b_src = sw_digit;
    end else begin : g_upper
      assign a_src = a_digits[(g-1)*DIGIT_W +: DIGIT_W];
      assign b_src = b_digits[(g-1)*DIGIT_W +: DIGIT_W];
    end

    bcd_digit_stage #(.DIGIT_W(DIGIT_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .clr     (clr),
      .ld_a    (ld_a),
      .ld_b    (ld_b),
      .a_in    (a_src),
      .b_in    (b_src),
      .swap    (swap),
      .cmp_in  (cmp_chain[g+1]),
      .a_q     (a_digits[g*DIGIT_W +: DIGIT_W]),
      .b_q     (b_digits[g*DIGIT_W +: DIGIT_W]),
      .min_d   (min_digits[g*DIGIT_W +: DIGIT_W]),
      .sub_d   (sub_digits[g*DIGIT_W +: DIGIT_W]),
      .cmp_out (cmp_chain[g])
    );
  end

  always_comb begin
    a_gt_b = (cmp_chain[0] == CMP_GT);
    a_lt_b = (cmp_chain[0] == CMP_LT);
  end

  logic unused_w;
  assign unused_w = ^TOTAL_W;

endmodule

// File: rtl/bcd_operand_regs_chk.sv
module bcd_operand_regs_chk #(
  parameter int DIGITS  = 3,
  parameter int DIGIT_W = 4
) (
  input logic                      clk,
  input logic                      rst_ok,
  input logic                      clr,
  input logic                      load,
  input logic                      sel_b,
  input logic [DIGIT_W-1:0]        sw_digit,
  input logic                      swap,
  input logic [DIGITS*DIGIT_W-1:0] a_digits,
  input logic [DIGITS*DIGIT_W-1:0] b_digits,
  input logic [DIGITS*DIGIT_W-1:0] min_digits,
  input logic [DIGITS*DIGIT_W-1:0] sub_digits,
  input logic                      a_gt_b,
  input logic                      a_lt_b
);

  localparam int TW = DIGITS * DIGIT_W;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_ok |-> (a_digits == '0 && b_digits == '0));

  // R2
  shift_a_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load && !sel_b && !clr) |=>
      a_digits == {$past(a_digits[TW-DIGIT_W-1:0]), $past(sw_digit)});

  // R3
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load && !sel_b && !clr) |=> $stable(b_digits));

  // R3
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load && sel_b && !clr) |=> $stable(a_digits));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    clr |=> (a_digits == '0 && b_digits == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && !clr) |=> ($stable(a_digits) && $stable(b_digits)));

  // R6
  cmp_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(a_gt_b && a_lt_b));

  // R6
  cmp_eq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (a_digits == b_digits) |-> (!a_gt_b && !a_lt_b));

  // R7
  swap_route_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    swap |-> (min_digits == b_digits && sub_digits == a_digits));

  // R7
  pass_route_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !swap |-> (min_digits == a_digits && sub_digits == b_digits));

endmodule

bind bcd_operand_regs bcd_operand_regs_chk #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .clr        (clr),
  .load       (load),
  .sel_b      (sel_b),
  .sw_digit   (sw_digit),
  .swap       (swap),
  .a_digits   (a_digits),
  .b_digits   (b_digits),
  .min_digits (min_digits),
  .sub_digits (sub_digits),
  .a_gt_b     (a_gt_b),
  .a_lt_b     (a_lt_b)
);

// File: tb/bcd_operand_regs_tb.sv
`timescale 1ns/1ps
module bcd_operand_regs_tb;

  localparam int DIGITS  = 3;
  localparam int DIGIT_W = 4;
  localparam int TW      = DIGITS * DIGIT_W;
  localparam int NVEC    = 7;

  // vector: {A, B, expect_gt, expect_lt}
  localparam logic [2*TW+1:0] VEC [NVEC] = '{
    {12'h123, 12'h123, 2'b00},
    {12'h500, 12'h499, 2'b10},
    {12'h099, 12'h100, 2'b01},
    {12'h987, 12'h978, 2'b10},
    {12'h000, 12'h001, 2'b01},
    {12'h450, 12'h405, 2'b10},
    {12'h999, 12'h999, 2'b00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic load = 1'b0;
  logic sel_b = 1'b0;
  logic [DIGIT_W-1:0] sw_digit = '0;
  logic swap = 1'b0;
  logic [TW-1:0] a_digits, b_digits, min_digits, sub_digits;
  logic a_gt_b, a_lt_b;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bcd_operand_regs #(.DIGITS(DIGITS), .DIGIT_W(DIGIT_W)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .load       (load),
    .sel_b      (sel_b),
    .sw_digit   (sw_digit),
    .swap       (swap),
    .a_digits   (a_digits),
    .b_digits   (b_digits),
    .min_digits (min_digits),
    .sub_digits (sub_digits),
    .a_gt_b     (a_gt_b),
    .a_lt_b     (a_lt_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic enter(input logic to_b, input logic [DIGIT_W-1:0] d);
    @(negedge clk);
    sel_b = to_b; sw_digit = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic enter_num(input logic to_b, input logic [TW-1:0] v);
    for (int k = DIGITS - 1; k >= 0; k--) enter(to_b, v[k*DIGIT_W +: DIGIT_W]);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: state during reset
    #20;
    chk("R1 a", a_digits, 0);
    chk("R1 b", b_digits, 0);
    chk("R1 cmp", {a_gt_b, a_lt_b}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R2 R3 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [TW-1:0] va, vb;
      va = VEC[i][2*TW+1 -: TW];
      vb = VEC[i][TW+1 -: TW];
      do_clear();
      enter_num(1'b0, va);
      chk("R2 a entry", a_digits, va);
      chk("R3 b held while a shifts", b_digits, 0);
      enter_num(1'b1, vb);
      chk("R3 b entry", b_digits, vb);
      chk("R3 a held while b shifts", a_digits, va);
      chk("R6 compare", {a_gt_b, a_lt_b}, VEC[i][1:0]);
      swap = 1'b0; #1;
      chk("R7 pass min", min_digits, va);
      chk("R7 pass sub", sub_digits, vb);
      swap = 1'b1; #1;
      chk("R7 swap min", min_digits, vb);
      chk("R7 swap sub", sub_digits, va);
      swap = 1'b0;
    end

    // R2: fourth digit drops the oldest
    do_clear();
    enter(1'b0, 4'h1); enter(1'b0, 4'h2); enter(1'b0, 4'h3); enter(1'b0, 4'h4);
    chk("R2 overflow shift", a_digits, 12'h234);

    // R5: idle cycles keep state
    enter_num(1'b1, 12'h876);
    repeat (5) @(negedge clk);
    chk("R5 a idle", a_digits, 12'h234);
    chk("R5 b idle", b_digits, 12'h876);
    chk("R6 lt", {a_gt_b, a_lt_b}, 2'b01);

    // R4: clear with load in same cycle
    @(negedge clk);
    clr = 1'b1; load = 1'b1; sel_b = 1'b0; sw_digit = 4'h7;
    @(negedge clk);
    clr = 1'b0; load = 1'b0;
    chk("R4 a clear over load", a_digits, 0);
    chk("R4 b clear", b_digits, 0);

    // R1: asynchronous reset mid-run
    enter_num(1'b0, 12'h555);
    enter_num(1'b1, 12'h321);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async a", a_digits, 0);
    chk("R1 async b", b_digits, 0);
    chk("R1 async cmp", {a_gt_b, a_lt_b}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    enter(1'b0, 4'h9);
    chk("R2 after reset", a_digits, 12'h009);
    chk("R6 gt low digit", {a_gt_b, a_lt_b}, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule